// File: doc/BRIEF.md
# Tree Broadcast Chunk Forwarding Scheduler

This block is the per-node controller of a tree broadcast. Each data chunk arrives as a notification from a parent. The notification carries the core that originated the broadcast, the message id, an end-of-message bit and the set of children this node has in that originator's tree. The controller picks where the chunk lands. If the local on-chip buffer is free and nothing is waiting, the chunk goes into the buffer and is forwarded at once. Otherwise the chunk is written into a private-memory slot and, when the node has children, queued for later forwarding. The node can also start its own broadcast from private memory into the buffer.

Data movement is outside the block. The controller issues one copy command at a time on a command/done handshake. Forwarding is one parallel notification to every child present. The buffer stays busy until every present child has acknowledged. When the buffer frees, the queue drains in arrival order, so a chunk that arrives later never passes one that is already waiting.

Top module: `chunk_fwd_sched`

## Requirements
- R1: After reset the buffer is available, the queue is empty, `in_ready` is high and no command, notification or pulse output is active.
- R2: An incoming chunk accepted while the buffer is available and the queue is empty gives a command with `mv_op` 0 (parent to buffer), and `buf_busy` reads 1 from the next cycle.
- R3: An incoming chunk accepted in any other case gives a command with `mv_op` 1 (parent to private slot) whose `mv_slot` is the queue's current write position, starting at 0 and wrapping after D-1.
- R4: A chunk received into a private slot is queued only when its child mask is non-zero. A chunk with no children leaves the write position and the fill level unchanged.
- R5: When the queue holds D entries, `q_full` is 1 and `in_ready` stays low; a stalled notification is held, not lost.
- R6: On completion of a copy from a parent, `par_ack` pulses for one cycle. If the chunk had its end-of-message bit set, `msg_done` pulses in the same cycle with the chunk's root and message id. A local send produces no `par_ack`.
- R7: The cycle after a buffer load completes for a chunk with children, `ntf_valid` pulses once. It carries the full child mask, the root and the message id.
- R8: `fwd_done` pulses and the buffer becomes available only once every child in the forwarded mask has pulsed its `kid_ack` bit. Acknowledges from children outside the mask have no effect, and the collected flags are cleared for the next forward.
- R9: A chunk loaded into the buffer with an empty child mask frees the buffer as soon as its copy completes, with no notification.
- R10: When the buffer is available and the queue is not empty, the oldest entry is drained first with `mv_op` 2 (private slot to buffer) from its slot. This takes priority over any waiting incoming chunk, so entries leave in arrival order.
- R11: A local send (`mv_op` 3, private memory to buffer) is accepted only when the buffer is available, the queue is empty and no incoming chunk is offered. It notifies with the send's child mask.
- R12: `mv_op` and `mv_slot` hold steady while `mv_valid` is high and until `mv_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming chunk notification offered |
| in_ready | output | 1 | Incoming notification accepted this cycle |
| in_root | input | RW | Originating core of the incoming chunk |
| in_msg | input | MW | Message id of the incoming chunk |
| in_eom | input | 1 | Incoming chunk is the last of its message |
| in_kids | input | K | Children of this node in the chunk's tree |
| snd_valid | input | 1 | Local broadcast chunk offered |
| snd_ready | output | 1 | Local chunk accepted this cycle |
| snd_root | input | RW | Root id of the local chunk |
| snd_msg | input | MW | Message id of the local chunk |
| snd_kids | input | K | Children of this node in its own tree |
| mv_valid | output | 1 | Copy command pending |
| mv_op | output | 2 | Copy kind: 0 parent to buffer, 1 parent to slot, 2 slot to buffer, 3 local to buffer |
| mv_slot | output | AW | Private slot used by ops 1 and 2 |
| mv_done | input | 1 | Copy finished |
| par_ack | output | 1 | Acknowledge pulse to the parent |
| ntf_valid | output | 1 | Parallel notification pulse to children |
| ntf_kids | output | K | Children notified |
| ntf_root | output | RW | Root id of the forwarded chunk |
| ntf_msg | output | MW | Message id of the forwarded chunk |
| kid_ack | input | K | Per-child acknowledge pulses |
| fwd_done | output | 1 | All notified children acknowledged |
| msg_done | output | 1 | Last chunk of a message received |
| done_root | output | RW | Root id of the completed message |
| done_msg | output | MW | Id of the completed message |
| buf_busy | output | 1 | Local buffer occupied |
| q_full | output | 1 | Forward queue holds D entries |

## Verification
The properties assume that `mv_done` arrives only while a command is pending and lasts a single cycle. They also assume that `kid_ack` bits are pulses, and that a caller holds `in_valid` with stable fields until it is taken. The bench's copy responder answers each command exactly once, two cycles after seeing it, and drops `mv_done` at the next falling edge. Acknowledges are one-cycle pulses issued only after a notification has been observed. Offers keep their fields steady until accepted, except the deliberate stall probe, which is withdrawn while the queue is full and before any acceptance could occur.

// File: rtl/chunk_fwd_sched.sv
module chunk_fwd_sched #(
  parameter int K  = 4,
  parameter int D  = 4,
  parameter int RW = 6,
  parameter int MW = 8,
  localparam int AW = (D > 1) ? $clog2(D) : 1,
  localparam int CW = $clog2(D + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [RW-1:0] in_root,
  input  logic [MW-1:0] in_msg,
  input  logic          in_eom,
  input  logic [K-1:0]  in_kids,
  input  logic          snd_valid,
  output logic          snd_ready,
  input  logic [RW-1:0] snd_root,
  input  logic [MW-1:0] snd_msg,
  input  logic [K-1:0]  snd_kids,
  output logic          mv_valid,
  output logic [1:0]    mv_op,
  output logic [AW-1:0] mv_slot,
  input  logic          mv_done,
  output logic          par_ack,
  output logic          ntf_valid,
  output logic [K-1:0]  ntf_kids,
  output logic [RW-1:0] ntf_root,
  output logic [MW-1:0] ntf_msg,
  input  logic [K-1:0]  kid_ack,
  output logic          fwd_done,
  output logic          msg_done,
  output logic [RW-1:0] done_root,
  output logic [MW-1:0] done_msg,
  output logic          buf_busy,
  output logic          q_full
);

  typedef enum logic [2:0] {M_IDLE, M_RXB, M_RXS, M_DRN, M_LOC} mst_t;

  localparam logic [1:0] OP_RXB = 2'd0;
  localparam logic [1:0] OP_RXS = 2'd1;
  localparam logic [1:0] OP_DRN = 2'd2;
  localparam logic [1:0] OP_LOC = 2'd3;

  mst_t          mst;
  logic          waiting;
  logic [K-1:0]  ack_q, cur_kids;
  logic [RW-1:0] c_root;
  logic [MW-1:0] c_msg;
  logic          c_eom;
  logic [K-1:0]  c_kids;

  logic [RW-1:0] q_root [D];
  logic [MW-1:0] q_msg  [D];
  logic [K-1:0]  q_kids [D];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] q_cnt;

  logic idle, q_empty, buf_path, go_drain, take_in, take_snd, all_acked;
  logic push, pop;

  assign idle      = (mst == M_IDLE);
  assign q_empty   = (q_cnt == '0);
  assign q_full    = (q_cnt == CW'(D));
  assign buf_path  = !buf_busy && q_empty;
  assign go_drain  = idle && !buf_busy && !q_empty;
  assign in_ready  = idle && !go_drain && (buf_path || !q_full);
  assign snd_ready = idle && buf_path && !in_valid;
  assign take_in   = in_valid && in_ready;
  assign take_snd  = snd_valid && snd_ready;
  assign all_acked = waiting && ((ack_q & cur_kids) == cur_kids);
  assign mv_valid  = !idle;
  assign push      = (mst == M_RXS) && mv_done && (|c_kids);
  assign pop       = (mst == M_DRN) && mv_done;

  always_ff @(posedge clk) begin
    if (push) begin
      q_root[wptr] <= c_root;
      q_msg[wptr]  <= c_msg;
      q_kids[wptr] <= c_kids;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      q_cnt <= '0;
    end else begin
      if (push) begin
        wptr  <= (wptr == AW'(D - 1)) ? '0 : wptr + 1'b1;
        q_cnt <= q_cnt + 1'b1;
      end
      if (pop) begin
        rptr  <= (rptr == AW'(D - 1)) ? '0 : rptr + 1'b1;
        q_cnt <= q_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mst       <= M_IDLE;
      buf_busy  <= 1'b0;
      waiting   <= 1'b0;
      ack_q     <= '0;
      cur_kids  <= '0;
      c_root    <= '0;
      c_msg     <= '0;
      c_eom     <= 1'b0;
      c_kids    <= '0;
      mv_op     <= OP_RXB;
      mv_slot   <= '0;
      par_ack   <= 1'b0;
      ntf_valid <= 1'b0;
      ntf_kids  <= '0;
      ntf_root  <= '0;
      ntf_msg   <= '0;
      fwd_done  <= 1'b0;
      msg_done  <= 1'b0;
      done_root <= '0;
      done_msg  <= '0;
    end else begin
      par_ack   <= 1'b0;
      ntf_valid <= 1'b0;
      fwd_done  <= 1'b0;
      msg_done  <= 1'b0;

      if (waiting) ack_q <= ack_q | kid_ack;
      if (all_acked) begin
        waiting  <= 1'b0;
        buf_busy <= 1'b0;
        ack_q    <= '0;
        fwd_done <= 1'b1;
      end

      if (idle) begin
        if (go_drain) begin
          mst      <= M_DRN;
          buf_busy <= 1'b1;
          mv_op    <= OP_DRN;
          mv_slot  <= rptr;
          c_root   <= q_root[rptr];
          c_msg    <= q_msg[rptr];
          c_kids   <= q_kids[rptr];
          c_eom    <= 1'b0;
        end else if (take_in) begin
          c_root  <= in_root;
          c_msg   <= in_msg;
          c_eom   <= in_eom;
          c_kids  <= in_kids;
          mv_slot <= wptr;
          if (buf_path) begin
            mst      <= M_RXB;
            buf_busy <= 1'b1;
            mv_op    <= OP_RXB;
          end else begin
            mst   <= M_RXS;
            mv_op <= OP_RXS;
          end
        end else if (take_snd) begin
          mst      <= M_LOC;
          buf_busy <= 1'b1;
          mv_op    <= OP_LOC;
          c_root   <= snd_root;
          c_msg    <= snd_msg;
          c_kids   <= snd_kids;
          c_eom    <= 1'b0;
        end
      end else if (mv_done) begin
        mst <= M_IDLE;
        if (mst == M_RXB || mst == M_RXS) begin
          par_ack <= 1'b1;
          if (c_eom) begin
            msg_done  <= 1'b1;
            done_root <= c_root;
            done_msg  <= c_msg;
          end
        end
        if (mst != M_RXS) begin
          if (|c_kids) begin
            ntf_valid <= 1'b1;
            ntf_kids  <= c_kids;
            ntf_root  <= c_root;
            ntf_msg   <= c_msg;
            waiting   <= 1'b1;
            cur_kids  <= c_kids;
          end else begin
            buf_busy <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/chunk_fwd_sched_chk.sv
module chunk_fwd_sched_chk #(
  parameter int D  = 4,
  parameter int CW = 3,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          buf_busy,
  input logic          q_full,
  input logic [CW-1:0] q_cnt,
  input logic          mv_valid,
  input logic [1:0]    mv_op,
  input logic [AW-1:0] mv_slot,
  input logic          mv_done,
  input logic          ntf_valid,
  input logic          fwd_done,
  input logic          par_ack
);

  // R2
  buf_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mv_valid) && mv_op == 2'd0 |-> $past(q_cnt) == '0 && !$past(buf_busy));

  // R5
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !in_ready);

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CW'(D));

  // R7
  ntf_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> buf_busy);

  // R8
  fwd_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_done |-> !buf_busy);

  // R6
  par_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_ack |-> $past(mv_done));

  // R12
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid && !mv_done |=> mv_valid && $stable(mv_op) && $stable(mv_slot));

endmodule

bind chunk_fwd_sched chunk_fwd_sched_chk #(.D(D), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .buf_busy(buf_busy),
  .q_full(q_full), .q_cnt(q_cnt), .mv_valid(mv_valid), .mv_op(mv_op),
  .mv_slot(mv_slot), .mv_done(mv_done), .ntf_valid(ntf_valid),
  .fwd_done(fwd_done), .par_ack(par_ack)
);

// File: tb/test_chunk_fwd_sched.sv
module test_chunk_fwd_sched;
  localparam int K = 4, D = 4, RW = 6, MW = 8, AW = 2;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_eom = 0, snd_valid = 0, mv_done = 0;
  logic [RW-1:0] in_root = 0, snd_root = 0;
  logic [MW-1:0] in_msg = 0, snd_msg = 0;
  logic [K-1:0] in_kids = 0, snd_kids = 0, kid_ack = 0;
  logic in_ready, snd_ready, mv_valid, par_ack, ntf_valid, fwd_done, msg_done, buf_busy, q_full;
  logic [1:0] mv_op;
  logic [AW-1:0] mv_slot;
  logic [K-1:0] ntf_kids;
  logic [RW-1:0] ntf_root, done_root;
  logic [MW-1:0] ntf_msg, done_msg;

  always #5 clk = ~clk;

  chunk_fwd_sched #(.K(K), .D(D), .RW(RW), .MW(MW)) i_chunk_fwd_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_root(in_root), .in_msg(in_msg), .in_eom(in_eom), .in_kids(in_kids),
    .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_root(snd_root),
    .snd_msg(snd_msg), .snd_kids(snd_kids), .mv_valid(mv_valid), .mv_op(mv_op),
    .mv_slot(mv_slot), .mv_done(mv_done), .par_ack(par_ack), .ntf_valid(ntf_valid),
    .ntf_kids(ntf_kids), .ntf_root(ntf_root), .ntf_msg(ntf_msg), .kid_ack(kid_ack),
    .fwd_done(fwd_done), .msg_done(msg_done), .done_root(done_root),
    .done_msg(done_msg), .buf_busy(buf_busy), .q_full(q_full));

  int nchk = 0, nfail = 0;
  int mv_n = 0, ntf_n = 0, pa_n = 0, md_n = 0, fd_n = 0, mv_changed = 0;
  int mv_op_l [64], mv_slot_l [64], ntf_kids_l [64], ntf_root_l [64], ntf_msg_l [64];
  int md_root_l = 0, md_msg_l = 0;
  bit finished = 0;

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  initial begin : monitor
    bit seen = 0;
    int fop = 0, fslot = 0;
    forever begin
      @(negedge clk);
      if (mv_valid && !seen) begin
        seen = 1; fop = mv_op; fslot = mv_slot;
        if (mv_n < 64) begin mv_op_l[mv_n] = mv_op; mv_slot_l[mv_n] = mv_slot; end
        mv_n++;
      end else if (mv_valid && (int'(mv_op) != fop || int'(mv_slot) != fslot)) mv_changed++;
      if (!mv_valid) seen = 0;
      if (par_ack) pa_n++;
      if (msg_done) begin md_n++; md_root_l = done_root; md_msg_l = done_msg; end
      if (fwd_done) fd_n++;
      if (ntf_valid) begin
        if (ntf_n < 64) begin
          ntf_kids_l[ntf_n] = ntf_kids; ntf_root_l[ntf_n] = ntf_root; ntf_msg_l[ntf_n] = ntf_msg;
        end
        ntf_n++;
      end
    end
  end

  initial begin : responder
    int age = 0;
    forever begin
      @(negedge clk);
      if (mv_done) mv_done = 0;
      else if (mv_valid) begin
        age++;
        if (age == 2) begin mv_done = 1; age = 0; end
      end else age = 0;
    end
  end

  task automatic offer(input int r, input int m, input bit e, input int k);
    @(negedge clk);
    in_root = RW'(r); in_msg = MW'(m); in_eom = e; in_kids = K'(k); in_valid = 1;
    #1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send(input int r, input int m, input int k);
    @(negedge clk);
    snd_root = RW'(r); snd_msg = MW'(m); snd_kids = K'(k); snd_valid = 1;
    #1;
    while (!snd_ready) @(negedge clk);
    @(negedge clk);
    snd_valid = 0;
  endtask

  task automatic ack(input int v);
    @(negedge clk); kid_ack = K'(v);
    @(negedge clk); kid_ack = 0;
    @(negedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  int exp_slot [5] = '{0, 1, 1, 2, 3};
  int dr_root [5] = '{5, 6, 7, 8, 12};
  int dr_kids [5] = '{1, 2, 4, 8, 15};
  int dr_slot [6] = '{0, 0, 1, 2, 3, 0};
  int dr_op [6] = '{2, 1, 2, 2, 2, 2};

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 in_ready", in_ready, 1);
    chk("R1 buf_busy", buf_busy, 0);
    chk("R1 q_full", q_full, 0);
    chk("R1 mv_valid", mv_valid, 0);
    chk("R1 ntf_valid", ntf_valid, 0);

    offer(3, 10, 0, 5);
    wait (ntf_n == 1);
    #1;
    chk("R2 op", mv_op_l[0], 0);
    chk("R2 buf_busy", buf_busy, 1);
    chk("R6 par_ack", pa_n, 1);
    chk("R7 kids", ntf_kids_l[0], 5);
    chk("R7 root", ntf_root_l[0], 3);
    chk("R7 msg", ntf_msg_l[0], 10);

    offer(5, 20, 0, 1);
    offer(9, 30, 1, 0);
    offer(6, 21, 0, 2);
    offer(7, 22, 0, 4);
    offer(8, 23, 0, 8);
    wait (mv_n == 6);
    wait (!mv_valid);
    @(negedge clk); #1;
    for (int i = 0; i < 5; i++) begin
      chk("R3 op", mv_op_l[1+i], 1);
      chk("R4 slot", mv_slot_l[1+i], exp_slot[i]);
    end
    chk("R4 q_full", q_full, 1);
    chk("R6 msg_done count", md_n, 1);
    chk("R6 done root", md_root_l, 9);
    chk("R6 done msg", md_msg_l, 30);
    chk("R6 par_ack count", pa_n, 6);
    chk("R7 no notify while busy", ntf_n, 1);

    @(negedge clk);
    in_root = 11; in_msg = 40; in_kids = 3; in_eom = 0; in_valid = 1;
    repeat (5) @(negedge clk);
    #1;
    chk("R5 stalled", in_ready, 0);
    chk("R5 no command", mv_n, 6);
    in_valid = 0;

    ack(1);
    chk("R8 partial", fd_n, 0);
    chk("R8 still busy", buf_busy, 1);
    ack(10);
    chk("R8 absent kids ignored", fd_n, 0);
    fork offer(12, 60, 0, 15); join_none
    ack(4);
    chk("R8 done", fd_n, 1);
    chk("R8 buffer freed", buf_busy, 0);

    for (int i = 0; i < 5; i++) begin
      wait (ntf_n == 2 + i);
      #1;
      chk("R10 drain root", ntf_root_l[1+i], dr_root[i]);
      chk("R10 drain kids", ntf_kids_l[1+i], dr_kids[i]);
      ack(dr_kids[i]);
    end
    wait (fd_n == 6);
    @(negedge clk); #1;
    for (int i = 0; i < 6; i++) begin
      chk("R10 order op", mv_op_l[6+i], dr_op[i]);
      chk("R10 order slot", mv_slot_l[6+i], dr_slot[i]);
    end
    chk("R10 q_full", q_full, 0);
    chk("R10 buf free", buf_busy, 0);

    send(1, 50, 6);
    wait (ntf_n == 7);
    #1;
    chk("R11 op", mv_op_l[12], 3);
    chk("R11 kids", ntf_kids_l[6], 6);
    chk("R11 root", ntf_root_l[6], 1);
    chk("R11 no parent ack", pa_n, 7);
    ack(6);

    for (int m = 0; m < 16; m++) begin
      int b0, n0, d0, f0;
      b0 = mv_n; n0 = ntf_n; d0 = md_n; f0 = fd_n;
      offer(m, 100 + m, m[0], m);
      wait (mv_n == b0 + 1);
      wait (!mv_valid);
      @(negedge clk); #1;
      chk("R2 sweep op", mv_op_l[b0], 0);
      chk("R6 sweep eom", md_n, d0 + (m & 1));
      if (m == 0) begin
        chk("R9 no notify", ntf_n, n0);
        chk("R9 buffer free", buf_busy, 0);
      end else begin
        int left;
        chk("R7 sweep kids", ntf_kids_l[n0], m);
        left = $countones(m);
        for (int b = 0; b < K; b++) begin
          if (m[b]) begin
            left--;
            ack(1 << b);
            chk("R8 sweep", fd_n, f0 + (left == 0 ? 1 : 0));
          end
        end
        chk("R8 sweep free", buf_busy, 0);
      end
    end

    chk("R12 command stable", mv_changed, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule